// File: doc/BRIEF.md
# Gate Pre-Driver Enable and Fault-Recovery Sequencer

This block is the digital power-mode and fault-recovery controller of a three-phase gate pre-driver. It takes an asynchronous enable level and a one-cycle reset-gate command from the serial interface. From these it drives the enables of the regulator, the charge pump, the current amplifiers and the gate-driver stage, together with a high-impedance request for the gate outputs and a flag that reports whether the serial interface is usable. It also holds three groups of sticky flags: gate-driver faults, status bits and a gate-supply overvoltage fault. Each flag sets from a synchronous fault-present level.

A cycle counter measures how long the synchronized enable stays low. The gate-driver stage drops at once. The support blocks stay powered for a programmable window. If enable comes back inside that window, the event is a quick fault reset: support power never drops and the gate stage returns at once. If enable stays low past the window, the block powers down fully and clears the overvoltage fault. A later enable then runs a staged power-up sequence.

Top module: `gate_enable_sequencer`

## Requirements
- R1: After `en_req_in` falls, `gd_en` reads 0 and `gate_hiz` reads 1 from the third rising clock edge onward. Two of these edges are the synchronizer and one is the state register.
- R2: After `gd_en` drops on a fall of enable, `reg_en`, `cp_en` and `amp_en` stay 1 for exactly `HOLD_CYCLES` clock cycles. They then all go to 0 if the synchronized enable is still low.
- R3: If the synchronized enable returns high inside the hold window, `reg_en`, `cp_en`, `amp_en` and `serial_ready` never drop. `gd_en` returns to 1 on the third edge after `en_req_in` rises.
- R4: A rising edge of the synchronized enable clears every gate-fault and status bit in the same cycle that the state leaves hold or off. A bit whose present input is high in that cycle is not cleared.
- R5: Power-up from the off state raises `reg_en` on the third edge after enable rises. It then raises `cp_en`, `amp_en` and `gd_en` in that order, each `STEP_CYCLES` cycles after the previous one.
- R6: A `reset_gate_cmd` pulse while `serial_ready` is 1 clears the gate-fault and status bits on the next edge and leaves every enable output unchanged.
- R7: `ovp_fault` is not cleared by a quick reset or by `reset_gate_cmd`. It clears on the edge where the hold window expires into the off state, unless `ovp_present` is high in that cycle.
- R8: In the off state, `serial_ready` is 0 and `reset_gate_cmd` has no effect on any flag.
- R9: Any flag whose present input is high in a cycle reads 1 after that edge, even when a clear occurs in the same cycle.
- R10: If the synchronized enable goes low during the power-up sequence, the sequence aborts and all enables read 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req_in | input | 1 | Asynchronous enable level |
| reset_gate_cmd | input | 1 | One-cycle reset-gate command from the serial interface |
| gate_flt_present | input | NUM_GATE_FLT | Gate-driver fault present levels |
| status_present | input | NUM_STATUS | Status condition present levels |
| ovp_present | input | 1 | Gate-supply overvoltage present level |
| reg_en | output | 1 | Regulator enable |
| cp_en | output | 1 | Charge pump enable |
| amp_en | output | 1 | Current amplifier enable |
| gd_en | output | 1 | Gate-driver stage enable |
| gate_hiz | output | 1 | Gate outputs high-impedance request |
| serial_ready | output | 1 | Serial interface available |
| gate_fault | output | NUM_GATE_FLT | Latched gate-driver faults |
| status_flags | output | NUM_STATUS | Latched status bits |
| ovp_fault | output | 1 | Latched overvoltage fault |

## Verification
The bench samples the support enables on every cycle of the hold window. It checks that the window is exactly `HOLD_CYCLES` long. A counter that is off by one would drop support one cycle early or late, and a wrong quick-reset path would let support power blink off. It keeps a gate-fault present input high through a rising enable and also pairs a present pulse with a reset command. A design that gave clear priority over set would lose a fault that is still active. It then issues reset commands and quick resets with the overvoltage flag set, and sends a command while the block is off. A design that cleared the overvoltage flag on any reset, or accepted commands in low-power mode, would clear flags there.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

    typedef enum logic [2:0] {
        GS_OFF  = 3'd0,
        GS_REG  = 3'd1,
        GS_CP   = 3'd2,
        GS_AMP  = 3'd3,
        GS_ON   = 3'd4,
        GS_HOLD = 3'd5
    } gs_state_e;

    typedef struct packed {
        logic reg_on;
        logic cp_on;
        logic amp_on;
        logic gd_on;
    } blk_en_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic blk_en_t decode_enables(input gs_state_e st);
        blk_en_t e;
        e.reg_on = (st != GS_OFF);
        e.cp_on  = (st == GS_CP) || (st == GS_AMP) || (st == GS_ON) || (st == GS_HOLD);
        e.amp_on = (st == GS_AMP) || (st == GS_ON) || (st == GS_HOLD);
        e.gd_on  = (st == GS_ON);
        return e;
    endfunction

endpackage

// File: rtl/gseq_sync.sv
module gseq_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic s1, s2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            prev <= 1'b0;
        end else begin
            s1   <= async_in;
            s2   <= s1;
            prev <= s2;
        end
    end

    assign level = s2;
    assign rise  = s2 & ~prev;
endmodule

// File: rtl/gseq_fault_bank.sv
module gseq_fault_bank #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] present,
    input  logic             clear,
    output logic [WIDTH-1:0] flags
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)             flags[i] <= 1'b0;
            else if (present[i]) flags[i] <= 1'b1;
            else if (clear)      flags[i] <= 1'b0;
        end

        // R9: set beats clear
        p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
            present[i] |=> flags[i]);
    end
endmodule

// File: rtl/gseq_fsm.sv
module gseq_fsm
    import gseq_pkg::*;
#(
    parameter int HOLD_CYCLES = 1000,
    parameter int STEP_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en_lvl,
    output logic reg_en,
    output logic cp_en,
    output logic amp_en,
    output logic gd_en,
    output logic hold_expire,
    output logic link_up
);
    localparam int CW = $clog2(max2(HOLD_CYCLES, STEP_CYCLES) + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);
    localparam logic [CW-1:0] STEP_LAST = CW'(STEP_CYCLES - 1);

    gs_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    blk_en_t       en_vec;

    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        hold_expire = 1'b0;
        case (state_q)
            GS_OFF: begin
                cnt_d = '0;
                if (en_lvl) state_d = GS_REG;
            end
            GS_REG, GS_CP, GS_AMP: begin
                if (!en_lvl) begin
                    state_d = GS_OFF;
                    cnt_d   = '0;
                end else if (cnt_q == STEP_LAST) begin
                    cnt_d   = '0;
                    state_d = (state_q == GS_REG) ? GS_CP :
                              (state_q == GS_CP)  ? GS_AMP : GS_ON;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            GS_ON: begin
                cnt_d = '0;
                if (!en_lvl) state_d = GS_HOLD;
            end
            GS_HOLD: begin
                if (en_lvl) begin
                    state_d = GS_ON;
                    cnt_d   = '0;
                end else if (cnt_q == HOLD_LAST) begin
                    state_d     = GS_OFF;
                    cnt_d       = '0;
                    hold_expire = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = GS_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GS_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign en_vec  = decode_enables(state_q);
    assign reg_en  = en_vec.reg_on;
    assign cp_en   = en_vec.cp_on;
    assign amp_en  = en_vec.amp_on;
    assign gd_en   = en_vec.gd_on;
    assign link_up = en_vec.reg_on;

    // R1: gate stage drops on the edge after low enable is seen in ON
    p_gate_drop_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == GS_ON && !en_lvl) |=> !gd_en);

    // R2: support blocks stay up while the window runs
    p_support_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == GS_HOLD && !en_lvl && cnt_q != HOLD_LAST) |=> (reg_en && cp_en && amp_en));

    // R3: quick return restores the gate stage directly
    p_quick_return_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == GS_HOLD && en_lvl) |=> (gd_en && cp_en && amp_en));

    // R5: charge pump only rises after regulator was already on
    p_order_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(cp_en) |-> $past(reg_en));

    // R10: abort during power-up
    p_abort_r10: assert property (@(posedge clk) disable iff (rst)
        (!en_lvl && reg_en && !gd_en && state_q != GS_HOLD) |=> !reg_en);
endmodule

// File: rtl/gate_enable_sequencer.sv
module gate_enable_sequencer
    import gseq_pkg::*;
#(
    parameter int HOLD_CYCLES  = 1000,
    parameter int STEP_CYCLES  = 16,
    parameter int NUM_GATE_FLT = 4,
    parameter int NUM_STATUS   = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en_req_in,
    input  logic                    reset_gate_cmd,
    input  logic [NUM_GATE_FLT-1:0] gate_flt_present,
    input  logic [NUM_STATUS-1:0]   status_present,
    input  logic                    ovp_present,
    output logic                    reg_en,
    output logic                    cp_en,
    output logic                    amp_en,
    output logic                    gd_en,
    output logic                    gate_hiz,
    output logic                    serial_ready,
    output logic [NUM_GATE_FLT-1:0] gate_fault,
    output logic [NUM_STATUS-1:0]   status_flags,
    output logic                    ovp_fault
);
    logic en_lvl, en_rise, hold_expire, cmd_ok, soft_clear;

    gseq_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (en_req_in),
        .level    (en_lvl),
        .rise     (en_rise)
    );

    gseq_fsm #(
        .HOLD_CYCLES (HOLD_CYCLES),
        .STEP_CYCLES (STEP_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .en_lvl      (en_lvl),
        .reg_en      (reg_en),
        .cp_en       (cp_en),
        .amp_en      (amp_en),
        .gd_en       (gd_en),
        .hold_expire (hold_expire),
        .link_up     (serial_ready)
    );

    assign gate_hiz   = ~gd_en;
    assign cmd_ok     = reset_gate_cmd & serial_ready;
    assign soft_clear = en_rise | cmd_ok;

    gseq_fault_bank #(.WIDTH(NUM_GATE_FLT)) u_gate_bank (
        .clk     (clk),
        .rst     (rst),
        .present (gate_flt_present),
        .clear   (soft_clear),
        .flags   (gate_fault)
    );

    gseq_fault_bank #(.WIDTH(NUM_STATUS)) u_status_bank (
        .clk     (clk),
        .rst     (rst),
        .present (status_present),
        .clear   (soft_clear),
        .flags   (status_flags)
    );

    gseq_fault_bank #(.WIDTH(1)) u_ovp_bank (
        .clk     (clk),
        .rst     (rst),
        .present (ovp_present),
        .clear   (hold_expire),
        .flags   (ovp_fault)
    );

    // R7: overvoltage flag only leaves through window expiry
    p_ovp_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (ovp_fault && !hold_expire) |=> ovp_fault);

    // R8: no flag clears while the serial side is down and no enable edge
    p_cmd_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (!serial_ready && !en_rise) |=> ((gate_fault & $past(gate_fault)) == $past(gate_fault)));

    // R6: an accepted command leaves power state alone
    p_cmd_keeps_power_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_ok && en_lvl && gd_en) |=> (gd_en && reg_en && cp_en && amp_en));
endmodule

// File: tb/gate_enable_sequencer_bench.sv
module gate_enable_sequencer_bench;
    localparam int HOLD = 20;
    localparam int STEP = 4;
    localparam int NG   = 4;
    localparam int NS   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_req_in = 1'b0;
    logic reset_gate_cmd = 1'b0;
    logic [NG-1:0] gate_flt_present = '0;
    logic [NS-1:0] status_present = '0;
    logic ovp_present = 1'b0;
    logic reg_en, cp_en, amp_en, gd_en, gate_hiz, serial_ready, ovp_fault;
    logic [NG-1:0] gate_fault;
    logic [NS-1:0] status_flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    gate_enable_sequencer #(
        .HOLD_CYCLES (HOLD),
        .STEP_CYCLES (STEP),
        .NUM_GATE_FLT(NG),
        .NUM_STATUS  (NS)
    ) u_gate_enable_sequencer (
        .clk              (clk),
        .rst              (rst),
        .en_req_in        (en_req_in),
        .reset_gate_cmd   (reset_gate_cmd),
        .gate_flt_present (gate_flt_present),
        .status_present   (status_present),
        .ovp_present      (ovp_present),
        .reg_en           (reg_en),
        .cp_en            (cp_en),
        .amp_en           (amp_en),
        .gd_en            (gd_en),
        .gate_hiz         (gate_hiz),
        .serial_ready     (serial_ready),
        .gate_fault       (gate_fault),
        .status_flags     (status_flags),
        .ovp_fault        (ovp_fault)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] pwr();
        return {reg_en, cp_en, amp_en, gd_en};
    endfunction

    task automatic pulse_cmd();
        reset_gate_cmd = 1'b1;
        step(1);
        reset_gate_cmd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R8 reset power", {28'd0, pwr()}, 32'h0);
        chk("R8 reset serial_ready", {31'd0, serial_ready}, 32'd0);
        chk("R1 reset hiz", {31'd0, gate_hiz}, 32'd1);
        chk("R8 reset flags", {24'd0, gate_fault, status_flags, ovp_fault}, 32'd0);
    endtask

    task automatic t_powerup();
        en_req_in = 1'b1;
        step(2);
        chk("R5 still off after sync", {28'd0, pwr()}, 32'h0);
        step(1);
        chk("R5 regulator first", {28'd0, pwr()}, 32'h8);
        chk("R5 serial up with regulator", {31'd0, serial_ready}, 32'd1);
        step(STEP - 1);
        chk("R5 cp not early", {28'd0, pwr()}, 32'h8);
        step(1);
        chk("R5 cp second", {28'd0, pwr()}, 32'hC);
        step(STEP);
        chk("R5 amp third", {28'd0, pwr()}, 32'hE);
        step(STEP);
        chk("R5 gate last", {28'd0, pwr()}, 32'hF);
        chk("R5 hiz released", {31'd0, gate_hiz}, 32'd0);
    endtask

    task automatic t_cmd_priority();
        gate_flt_present = 4'b0010;
        status_present   = 3'b100;
        step(1);
        chk("R9 gate fault latched", {28'd0, gate_fault}, 32'h2);
        gate_flt_present = 4'b0000;
        status_present   = 3'b000;
        step(1);
        chk("R9 gate fault sticky", {28'd0, gate_fault}, 32'h2);
        gate_flt_present = 4'b0010;
        pulse_cmd();
        chk("R9 set beats command", {28'd0, gate_fault}, 32'h2);
        chk("R6 status cleared by command", {29'd0, status_flags}, 32'h0);
        gate_flt_present = 4'b0000;
        pulse_cmd();
        chk("R6 gate fault cleared by command", {28'd0, gate_fault}, 32'h0);
        chk("R6 power unchanged by command", {28'd0, pwr()}, 32'hF);
    endtask

    task automatic t_quick_reset();
        gate_flt_present = 4'b1001;
        status_present   = 3'b010;
        ovp_present      = 1'b1;
        step(1);
        gate_flt_present = 4'b1000;
        status_present   = 3'b000;
        ovp_present      = 1'b0;
        pulse_cmd();
        chk("R7 ovp survives command", {31'd0, ovp_fault}, 32'd1);
        en_req_in = 1'b0;
        step(2);
        chk("R1 gate still on before state edge", {31'd0, gd_en}, 32'd1);
        step(1);
        chk("R1 gate off", {31'd0, gd_en}, 32'd0);
        chk("R1 hiz asserted", {31'd0, gate_hiz}, 32'd1);
        for (int k = 0; k < 5; k++) begin
            step(1);
            chk("R3 support held in glitch", {28'd0, pwr()}, 32'hE);
            chk("R3 serial held in glitch", {31'd0, serial_ready}, 32'd1);
        end
        en_req_in = 1'b1;
        for (int k = 0; k < 2; k++) begin
            step(1);
            chk("R3 support held on return", {28'd0, pwr()}, 32'hE);
        end
        step(1);
        chk("R3 gate back", {28'd0, pwr()}, 32'hF);
        chk("R4 present bit kept, other cleared", {28'd0, gate_fault}, 32'h8);
        chk("R4 status cleared", {29'd0, status_flags}, 32'h0);
        chk("R7 ovp survives quick reset", {31'd0, ovp_fault}, 32'd1);
        gate_flt_present = 4'b0000;
        pulse_cmd();
    endtask

    task automatic t_full_shutdown();
        en_req_in = 1'b0;
        step(3);
        chk("R1 gate off before shutdown", {28'd0, pwr()}, 32'hE);
        step(HOLD - 1);
        chk("R2 support up at window end", {28'd0, pwr()}, 32'hE);
        chk("R7 ovp still set in window", {31'd0, ovp_fault}, 32'd1);
        step(1);
        chk("R2 all off after window", {28'd0, pwr()}, 32'h0);
        chk("R8 serial down when off", {31'd0, serial_ready}, 32'd0);
        chk("R7 ovp cleared by full shutdown", {31'd0, ovp_fault}, 32'd0);
    endtask

    task automatic t_off_ignore();
        gate_flt_present = 4'b0100;
        step(1);
        gate_flt_present = 4'b0000;
        pulse_cmd();
        chk("R8 command ignored when off", {28'd0, gate_fault}, 32'h4);
        step(1);
        chk("R8 still off", {28'd0, pwr()}, 32'h0);
    endtask

    task automatic t_abort();
        en_req_in = 1'b1;
        step(3);
        chk("R4 rising enable clears flags", {28'd0, gate_fault}, 32'h0);
        chk("R10 power-up started", {28'd0, pwr()}, 32'h8);
        en_req_in = 1'b0;
        step(2);
        chk("R10 before abort edge", {31'd0, reg_en}, 32'd1);
        step(1);
        chk("R10 aborted", {28'd0, pwr()}, 32'h0);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_powerup();
        t_cmd_priority();
        t_quick_reset();
        t_full_shutdown();
        t_off_ignore();
        t_abort();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule